// File: doc/BRIEF.md
# Dual-Buffer Operation Interlock

This block sits between the command decoder and the array sequencer of a serial memory with two SRAM page buffers. Each decoded command arrives as a one-cycle request carrying a class bit, a command code and a buffer index. Array-class operations are long jobs that occupy the memory array. Buffer-class operations touch only one of the page buffers. The block keeps a small record of the array-class job in flight: whether one is running and, if so, which buffer it holds. From that record it answers every request with either a grant or a reject.

The rules let a controller stream data. While buffer 0 is being written into the array, buffer 1 can be refilled, and the same holds with the buffers swapped. A second array-class job is refused until the sequencer reports completion. The record is cleared by a one-cycle done pulse from the sequencer. A request presented in the same cycle as that pulse is judged as if the array were already free.

Top module: `dbuf_interlock`

## Requirements
- R1: A synchronous reset (`rst` high) clears the record: no job active, no buffer held, `grant` and `reject` low. The first array-class request after reset is granted.
- R2: Every request (`req_valid` high for one cycle) is answered exactly one cycle later by a one-cycle pulse on exactly one of `grant` or `reject`. In a cycle after no request, both outputs are low.
- R3: An array-class request (`req_class` = 1) is rejected while an earlier array-class job has not completed, whatever its command code.
- R4: The two direct array read codes (`req_cmd` 0 = streaming read, 1 = single page read) are granted only when no array-class job is active. Once granted, they block further array-class requests until done.
- R5: A buffer-class request (`req_class` = 0) is granted during an array-class job if it targets the buffer that job does not hold. While a program from buffer 0 runs, buffer 1 is accepted, and the reverse is also true.
- R6: Array-class codes 2 (program array from buffer) and 3 (transfer array page into buffer) hold the buffer named by `req_buf`. A buffer-class request naming the held buffer is rejected until the job completes.
- R7: Array-class jobs with any other code (0, 1, 4 to 7) hold no buffer. Every buffer-class request is granted while they run.
- R8: A `seq_done` pulse ends the active job. A request presented in the same cycle as that pulse is judged with the array free: an array-class request is granted, and a buffer-class request on the formerly held buffer is granted.
- R9: `seq_done` while idle produces no output and changes nothing. A rejected array-class request leaves the existing record unchanged, including the held buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request strobe |
| req_class | input | 1 | 1 = array-class, 0 = buffer-class |
| req_cmd | input | 3 | Command code |
| req_buf | input | BUF_W (1) | Buffer index targeted or held |
| seq_done | input | 1 | One-cycle completion pulse from the array sequencer |
| grant | output | 1 | Request accepted, one cycle after the request |
| reject | output | 1 | Request refused, one cycle after the request |

## Verification
A bound checker keeps its own shadow of the active job, built from past grants and request fields. On every cycle it checks four things: grant and reject never coincide, each request gets exactly one answer, an array-class request against a live job is refused, and a buffer-class request is judged against the held buffer. This includes the case where a done pulse lands in the same cycle as the request. Some behaviours only the bench scenarios can show. These are the full sweep of every holder code against every follow-up code and buffer, the fact that a rejected array request does not overwrite the held buffer, and recovery from a reset issued mid-job.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    localparam int CMD_W = 3;

    typedef enum logic {
        CLS_BUF   = 1'b0,
        CLS_ARRAY = 1'b1
    } cls_e;

    localparam logic [CMD_W-1:0] OP_RD_STREAM = 3'd0;
    localparam logic [CMD_W-1:0] OP_RD_PAGE   = 3'd1;
    localparam logic [CMD_W-1:0] OP_PROG_BUF  = 3'd2;
    localparam logic [CMD_W-1:0] OP_LOAD_BUF  = 3'd3;
    localparam logic [CMD_W-1:0] OP_ERASE     = 3'd4;
endpackage

// File: rtl/ilk_decode.sv
module ilk_decode
    import dbi_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output logic             holds_buf
);
    // Array-class codes that keep a page buffer busy for their whole run.
    always_comb begin
        holds_buf = (cmd == OP_PROG_BUF) || (cmd == OP_LOAD_BUF);
    end
endmodule

// File: rtl/ilk_arbiter.sv
module ilk_arbiter #(
    parameter int BUF_W = 1
) (
    input  logic             req_valid,
    input  logic             req_is_array,
    input  logic [BUF_W-1:0] req_buf,
    input  logic             act_busy,
    input  logic             act_holds,
    input  logic [BUF_W-1:0] act_buf,
    input  logic             seq_done,
    output logic             ok,
    output logic             start_array
);
    logic live;
    logic conflict;

    always_comb begin
        // A done pulse frees the array in the same cycle.
        live        = act_busy && !seq_done;
        conflict    = live && act_holds && (act_buf == req_buf);
        ok          = req_is_array ? !live : !conflict;
        start_array = req_valid && req_is_array && ok;
    end
endmodule

// File: rtl/ilk_record.sv
module ilk_record #(
    parameter int BUF_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seq_done,
    input  logic             start_array,
    input  logic             start_holds,
    input  logic [BUF_W-1:0] start_buf,
    input  logic             resp_valid,
    input  logic             resp_ok,
    output logic             act_busy,
    output logic             act_holds,
    output logic [BUF_W-1:0] act_buf,
    output logic             grant,
    output logic             reject
);
    typedef struct packed {
        logic             active;
        logic             holds;
        logic [BUF_W-1:0] bsel;
        logic             grant;
        logic             reject;
    } rec_t;

    rec_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.grant  = resp_valid && resp_ok;
        st_d.reject = resp_valid && !resp_ok;
        if (seq_done) begin
            st_d.active = 1'b0;
            st_d.holds  = 1'b0;
        end
        if (start_array) begin
            st_d.active = 1'b1;
            st_d.holds  = start_holds;
            st_d.bsel   = start_buf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign act_busy  = st_q.active;
    assign act_holds = st_q.holds;
    assign act_buf   = st_q.bsel;
    assign grant     = st_q.grant;
    assign reject    = st_q.reject;
endmodule

// File: rtl/dbuf_interlock.sv
module dbuf_interlock
    import dbi_pkg::*;
#(
    parameter int NUM_BUF = 2,
    localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_class,
    input  logic [CMD_W-1:0] req_cmd,
    input  logic [BUF_W-1:0] req_buf,
    input  logic             seq_done,
    output logic             grant,
    output logic             reject
);
    logic             holds_buf;
    logic             ok;
    logic             start_array;
    logic             act_busy;
    logic             act_holds;
    logic [BUF_W-1:0] act_buf;
    logic             is_array;

    assign is_array = (cls_e'(req_class) == CLS_ARRAY);

    ilk_decode u_dec (
        .cmd       (req_cmd),
        .holds_buf (holds_buf)
    );

    ilk_arbiter #(.BUF_W(BUF_W)) u_arb (
        .req_valid    (req_valid),
        .req_is_array (is_array),
        .req_buf      (req_buf),
        .act_busy     (act_busy),
        .act_holds    (act_holds),
        .act_buf      (act_buf),
        .seq_done     (seq_done),
        .ok           (ok),
        .start_array  (start_array)
    );

    ilk_record #(.BUF_W(BUF_W)) u_rec (
        .clk         (clk),
        .rst         (rst),
        .seq_done    (seq_done),
        .start_array (start_array),
        .start_holds (holds_buf),
        .start_buf   (req_buf),
        .resp_valid  (req_valid),
        .resp_ok     (ok),
        .act_busy    (act_busy),
        .act_holds   (act_holds),
        .act_buf     (act_buf),
        .grant       (grant),
        .reject      (reject)
    );
endmodule

// File: rtl/dbi_checker.sv
module dbi_checker #(
    parameter int BUF_W = 1,
    parameter int CMD_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_class,
    input logic [CMD_W-1:0] req_cmd,
    input logic [BUF_W-1:0] req_buf,
    input logic             seq_done,
    input logic             grant,
    input logic             reject
);
    // Shadow of the running job, rebuilt from answered requests.
    logic             p_class, p_hold;
    logic [BUF_W-1:0] p_buf;
    logic             s_act, s_hold;
    logic [BUF_W-1:0] s_buf;
    logic             e_act, e_hold;
    logic [BUF_W-1:0] e_buf;
    logic             e_live, e_clash;

    always_comb begin
        e_act   = s_act;
        e_hold  = s_hold;
        e_buf   = s_buf;
        if (grant && p_class) begin
            e_act  = 1'b1;
            e_hold = p_hold;
            e_buf  = p_buf;
        end
        e_live  = e_act && !seq_done;
        e_clash = e_live && e_hold && (e_buf == req_buf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_class <= 1'b0;
            p_hold  <= 1'b0;
            p_buf   <= '0;
            s_act   <= 1'b0;
            s_hold  <= 1'b0;
            s_buf   <= '0;
        end else begin
            p_class <= req_valid && req_class;
            p_hold  <= (req_cmd == 3'd2) || (req_cmd == 3'd3);
            p_buf   <= req_buf;
            s_act   <= e_live;
            s_hold  <= e_hold && e_live;
            s_buf   <= e_buf;
        end
    end

    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(grant && reject));
    a_r2_one_answer: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (grant != reject));
    a_r2_silent: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!grant && !reject));
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!grant && !reject));
    a_r3_second_array: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class && e_live) |=> reject);
    a_r8_free_array: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class && !e_live) |=> grant);
    a_r6_held_buffer: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_class && e_clash) |=> reject);
    a_r5_other_buffer: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_class && !e_clash) |=> grant);
endmodule

bind dbuf_interlock dbi_checker #(.BUF_W(BUF_W), .CMD_W(dbi_pkg::CMD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_class (req_class),
    .req_cmd   (req_cmd),
    .req_buf   (req_buf),
    .seq_done  (seq_done),
    .grant     (grant),
    .reject    (reject)
);

// File: tb/sim_dbuf_interlock.sv
module sim_dbuf_interlock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_class = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [0:0] req_buf = 1'b0;
    logic       seq_done = 1'b0;
    logic       grant, reject;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit m_act  = 1'b0;
    bit m_hold = 1'b0;
    int m_buf  = 0;

    always #4 clk = ~clk;   // 125 MHz

    dbuf_interlock u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .req_cmd(req_cmd), .req_buf(req_buf), .seq_done(seq_done),
        .grant(grant), .reject(reject)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string tag, bit g, bit r, bit eg, bit er);
        checks++;
        if (g !== eg || r !== er) begin
            errors++;
            $display("FAIL %s: actual grant=%0b reject=%0b expected grant=%0b reject=%0b",
                     tag, g, r, eg, er);
        end
    endtask

    task automatic issue(string tag, bit cls, int cmd, int b, bit done);
        bit live, clash, ok;
        live  = m_act && !done;
        clash = live && m_hold && (m_buf == b);
        ok    = cls ? !live : !clash;
        @(negedge clk);
        req_valid = 1'b1; req_class = cls; req_cmd = 3'(cmd);
        req_buf = 1'(b); seq_done = done;
        @(negedge clk);
        req_valid = 1'b0; seq_done = 1'b0;
        chk(tag, grant, reject, ok, !ok);
        if (done) begin m_act = 1'b0; m_hold = 1'b0; end
        if (cls && ok) begin
            m_act = 1'b1; m_hold = (cmd == 2 || cmd == 3); m_buf = b;
        end
    endtask

    task automatic finish_job(string tag);
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
        chk(tag, grant, reject, 1'b0, 1'b0);
        m_act = 1'b0; m_hold = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", grant, reject, 1'b0, 1'b0);
        finish_job("R9 done while idle");
        issue("R1 first array request", 1'b1, 4, 0, 1'b0);
        finish_job("R2 quiet on done");

        // Sweep: every holder code and buffer against every follow-up.
        for (int h = 0; h < 8; h++) begin
            for (int hb = 0; hb < 2; hb++) begin
                issue((h < 2) ? "R4 read from idle" : "R1 array from idle", 1'b1, h, hb, 1'b0);
                for (int c = 0; c < 8; c++) begin
                    for (int b = 0; b < 2; b++) begin
                        if (h == 2 || h == 3)
                            issue((b == hb) ? "R6 held buffer" : "R5 other buffer", 1'b0, c, b, 1'b0);
                        else
                            issue("R7 no buffer held", 1'b0, c, b, 1'b0);
                        issue((c < 2) ? "R4 read overlaps" : "R3 second array", 1'b1, c, b, 1'b0);
                    end
                end
                finish_job("R2 no answer without request");
            end
        end

        // Same-cycle completion.
        issue("R5 program buf0", 1'b1, 2, 0, 1'b0);
        issue("R5 load buf1", 1'b0, 5, 1, 1'b0);
        issue("R8 held buf freed by done", 1'b0, 5, 0, 1'b1);
        issue("R8 program buf1", 1'b1, 2, 1, 1'b0);
        issue("R8 read with done", 1'b1, 0, 0, 1'b1);
        issue("R7 buffer during read", 1'b0, 1, 1, 1'b0);
        issue("R4 array during read", 1'b1, 3, 0, 1'b0);
        finish_job("R8 end read");

        // Rejected array request leaves the record alone.
        issue("R6 program buf0", 1'b1, 2, 0, 1'b0);
        issue("R9 rejected array", 1'b1, 3, 1, 1'b0);
        issue("R9 buf1 still free", 1'b0, 0, 1, 1'b0);
        issue("R9 buf0 still held", 1'b0, 0, 0, 1'b0);

        // Reset in the middle of a job.
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_act = 1'b0; m_hold = 1'b0;
        chk("R1 reset mid job", grant, reject, 1'b0, 1'b0);
        issue("R1 buf0 free after reset", 1'b0, 0, 0, 1'b0);
        issue("R1 array after reset", 1'b1, 1, 0, 1'b0);
        finish_job("R2 final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule